// File: doc/BRIEF.md
# DAC Channel Update Sequencer

This block is the host-side master that pushes one 16-bit code to one of eight DAC channels behind a byte-wide register port. The channels are split into two banks of four. Each bank owns a window of four byte registers: two data bytes at offsets 0 and 1, a command byte at offset 2 and a status byte at offset 3 whose bit 7 signals ready. The second bank's window sits four addresses above the first.

An accepted request runs a fixed script. It writes the range code, writes a zero byte, issues a setup command and polls for ready. It then writes the low and high data bytes, issues a load-and-convert command and polls for ready again. A poll that never sees ready is abandoned after a parameterised number of reads, and the update ends with an error. The block keeps a shadow copy of the last value that completed on each channel. That copy can be read back combinationally at any time without using the bus.

Top module: `dac_upd_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `bus_wr`, `bus_rd` and `done_valid` are 0, and every channel's shadow reads back as 0.
- R2: For channel c in 0..7, bank b = c/4 and in-bank index i = c%4. Every bus access of the update uses address 4*b + offset, with the offset in the low two address bits.
- R3: The first write of an update goes to offset 0 with data {4'b0, range[3:0]}. The second write goes to offset 1 with data 0x00.
- R4: The third write goes to offset 2 with the setup command 0x60 | (i << 1).
- R5: A ready wait reads offset 3 once per cycle (`bus_rd` high, no write that cycle). It moves on in the cycle after a read returns bit 7 = 1; the other bits of the read data are ignored.
- R6: After the first wait succeeds, the fourth write goes to offset 0 with value[7:0] and the fifth goes to offset 1 with value[15:8].
- R7: The sixth write goes to offset 2 with the trigger command 0x70 | (i << 1), and a second ready wait follows.
- R8: `rd_value` always equals the shadow of channel `rd_chan`. A channel's shadow takes the requested value only when its second ready wait succeeds, and the bus shows no access caused by readback.
- R9: If a wait sees POLL_LIMIT reads without bit 7 set, the update stops after exactly POLL_LIMIT reads. No further writes occur, `done_err` is 1 on the done pulse, and no shadow changes.
- R10: A request with `req_chan` of 8 or above is ignored: no bus access, no done pulse, and `req_ready` stays 1.
- R11: Every accepted update ends with `done_valid` high for exactly one cycle, with `done_err` 0 on success. `req_ready` is 1 again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Update request strobe, taken when `req_ready` is 1 |
| req_chan | input | 4 | Target channel, 0..7 valid |
| req_value | input | 16 | Code to write |
| req_range | input | 8 | Range code; only bits 3:0 are used |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| done_valid | output | 1 | One-cycle end-of-update pulse |
| done_err | output | 1 | Ready-wait timeout flag, valid with `done_valid` |
| rd_chan | input | 3 | Channel selected for shadow readback |
| rd_value | output | 16 | Shadow value of `rd_chan` |
| bus_wr | output | 1 | Byte write strobe |
| bus_rd | output | 1 | Status read strobe; `bus_rdata` is sampled at the closing edge |
| bus_addr | output | 3 | Byte register address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data |

## Verification
Several properties are checked every cycle: reads and writes never overlap, a read only ever targets the status offset, command bytes always carry a setup or trigger opcode with bit 0 clear, and the done pulse lasts one cycle and is followed by idle. Other cycle checks confirm that a request for channel 8 or above leaves the block idle, and that a shadow value only changes on a successful done. The exact order of addresses and bytes, the poll counts around the timeout boundary (ready on the last allowed read versus one read too late), and the effect of a timeout in either wait on the write count and the shadows can only be shown by the bench. The bench drives scripted updates over all channels with chosen ready delays and compares the logged bus traffic to values it computes itself.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RANGE,
        S_ZERO,
        S_SETUP,
        S_WAIT1,
        S_LO,
        S_HI,
        S_TRIG,
        S_WAIT2,
        S_DONE
    } seq_state_e;

    localparam logic [7:0] OP_SETUP   = 8'h60;
    localparam logic [7:0] OP_TRIG    = 8'h70;
    localparam int         READY_BIT  = 7;
    localparam int         RANGE_BITS = 4;

    localparam logic [1:0] OFS_LO   = 2'd0;
    localparam logic [1:0] OFS_HI   = 2'd1;
    localparam logic [1:0] OFS_CMD  = 2'd2;
    localparam logic [1:0] OFS_STAT = 2'd3;

endpackage

// File: rtl/dac_poll_timer.sv
module dac_poll_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)     cnt_d = '0;
        else if (step) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/dac_shadow_bank.sv
module dac_shadow_bank #(
    parameter int N_CHAN = 8,
    parameter int DATA_W = 16,
    localparam int SEL_W = $clog2(N_CHAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_chan,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_chan,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] shadow_q [N_CHAN];

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        logic [DATA_W-1:0] val_d;

        always_comb begin
            val_d = shadow_q[g];
            if (wr_en && (wr_chan == SEL_W'(g))) val_d = wr_data;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) shadow_q[g] <= '0;
            else        shadow_q[g] <= val_d;
        end
    end

    assign rd_data = shadow_q[rd_chan];
endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
    import dac_seq_pkg::*;
#(
    parameter int N_CHAN        = 8,
    parameter int BANK_CHANS    = 4,
    parameter int REGS_PER_BANK = 4,
    parameter int DATA_W        = 16,
    parameter int REQ_CHAN_W    = 4,
    parameter int RANGE_W       = 8,
    parameter int ADDR_W        = 3,
    localparam int SEL_W = $clog2(N_CHAN),
    localparam int IDX_W = $clog2(BANK_CHANS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [REQ_CHAN_W-1:0] req_chan,
    input  logic [DATA_W-1:0]     req_value,
    input  logic [RANGE_W-1:0]    req_range,
    output logic                  req_ready,
    output logic                  done_valid,
    output logic                  done_err,
    output logic                  bus_wr,
    output logic                  bus_rd,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [7:0]            bus_wdata,
    input  logic [7:0]            bus_rdata,
    output logic                  poll_clear,
    output logic                  poll_step,
    input  logic                  poll_last,
    output logic                  commit,
    output logic [SEL_W-1:0]      commit_chan,
    output logic [DATA_W-1:0]     commit_value
);
    localparam logic [REQ_CHAN_W-1:0] CHAN_LIM = REQ_CHAN_W'(N_CHAN);

    typedef struct packed {
        seq_state_e          state;
        logic [SEL_W-1:0]    chan;
        logic [DATA_W-1:0]   value;
        logic [RANGE_BITS-1:0] range;
        logic                err;
    } seq_t;

    seq_t st_d, st_q;

    logic [ADDR_W-1:0] base;
    logic [IDX_W-1:0]  idx;
    logic              ready_seen;

    always_comb begin
        base       = ADDR_W'((int'(st_q.chan) / BANK_CHANS) * REGS_PER_BANK);
        idx        = IDX_W'(int'(st_q.chan) % BANK_CHANS);
        ready_seen = bus_rdata[READY_BIT];

        st_d         = st_q;
        req_ready    = 1'b0;
        done_valid   = 1'b0;
        done_err     = 1'b0;
        bus_wr       = 1'b0;
        bus_rd       = 1'b0;
        bus_addr     = base;
        bus_wdata    = 8'h00;
        poll_clear   = 1'b1;
        poll_step    = 1'b0;
        commit       = 1'b0;
        commit_chan  = st_q.chan;
        commit_value = st_q.value;

        unique case (st_q.state)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid && (req_chan < CHAN_LIM)) begin
                    st_d.state = S_RANGE;
                    st_d.chan  = SEL_W'(req_chan);
                    st_d.value = req_value;
                    st_d.range = req_range[RANGE_BITS-1:0];
                    st_d.err   = 1'b0;
                end
            end
            S_RANGE: begin
                bus_wr     = 1'b1;
                bus_addr   = base | ADDR_W'(OFS_LO);
                bus_wdata  = 8'(st_q.range);
                st_d.state = S_ZERO;
            end
            S_ZERO: begin
                bus_wr     = 1'b1;
                bus_addr   = base | ADDR_W'(OFS_HI);
                bus_wdata  = 8'h00;
                st_d.state = S_SETUP;
            end
            S_SETUP: begin
                bus_wr     = 1'b1;
                bus_addr   = base | ADDR_W'(OFS_CMD);
                bus_wdata  = OP_SETUP | (8'(idx) << 1);
                st_d.state = S_WAIT1;
            end
            S_WAIT1, S_WAIT2: begin
                bus_rd     = 1'b1;
                bus_addr   = base | ADDR_W'(OFS_STAT);
                poll_clear = 1'b0;
                if (ready_seen) begin
                    poll_clear = 1'b1;
                    if (st_q.state == S_WAIT1) begin
                        st_d.state = S_LO;
                    end else begin
                        commit     = 1'b1;
                        st_d.state = S_DONE;
                    end
                end else if (poll_last) begin
                    poll_clear = 1'b1;
                    st_d.err   = 1'b1;
                    st_d.state = S_DONE;
                end else begin
                    poll_step = 1'b1;
                end
            end
            S_LO: begin
                bus_wr     = 1'b1;
                bus_addr   = base | ADDR_W'(OFS_LO);
                bus_wdata  = st_q.value[7:0];
                st_d.state = S_HI;
            end
            S_HI: begin
                bus_wr     = 1'b1;
                bus_addr   = base | ADDR_W'(OFS_HI);
                bus_wdata  = st_q.value[15:8];
                st_d.state = S_TRIG;
            end
            S_TRIG: begin
                bus_wr     = 1'b1;
                bus_addr   = base | ADDR_W'(OFS_CMD);
                bus_wdata  = OP_TRIG | (8'(idx) << 1);
                st_d.state = S_WAIT2;
            end
            S_DONE: begin
                done_valid = 1'b1;
                done_err   = st_q.err;
                st_d.state = S_IDLE;
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state <= S_IDLE;
            st_q.chan  <= '0;
            st_q.value <= '0;
            st_q.range <= '0;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dac_upd_seq.sv
module dac_upd_seq #(
    parameter int N_CHAN        = 8,
    parameter int BANK_CHANS    = 4,
    parameter int REGS_PER_BANK = 4,
    parameter int DATA_W        = 16,
    parameter int REQ_CHAN_W    = 4,
    parameter int RANGE_W       = 8,
    parameter int ADDR_W        = 3,
    parameter int POLL_LIMIT    = 100000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [REQ_CHAN_W-1:0]  req_chan,
    input  logic [DATA_W-1:0]      req_value,
    input  logic [RANGE_W-1:0]     req_range,
    output logic                   req_ready,
    output logic                   done_valid,
    output logic                   done_err,
    input  logic [$clog2(N_CHAN)-1:0] rd_chan,
    output logic [DATA_W-1:0]      rd_value,
    output logic                   bus_wr,
    output logic                   bus_rd,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic [7:0]             bus_wdata,
    input  logic [7:0]             bus_rdata
);
    localparam int SEL_W = $clog2(N_CHAN);

    logic              poll_clear, poll_step, poll_last;
    logic              commit;
    logic [SEL_W-1:0]  commit_chan;
    logic [DATA_W-1:0] commit_value;

    dac_seq_ctrl #(
        .N_CHAN        (N_CHAN),
        .BANK_CHANS    (BANK_CHANS),
        .REGS_PER_BANK (REGS_PER_BANK),
        .DATA_W        (DATA_W),
        .REQ_CHAN_W    (REQ_CHAN_W),
        .RANGE_W       (RANGE_W),
        .ADDR_W        (ADDR_W)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_chan     (req_chan),
        .req_value    (req_value),
        .req_range    (req_range),
        .req_ready    (req_ready),
        .done_valid   (done_valid),
        .done_err     (done_err),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .poll_clear   (poll_clear),
        .poll_step    (poll_step),
        .poll_last    (poll_last),
        .commit       (commit),
        .commit_chan  (commit_chan),
        .commit_value (commit_value)
    );

    dac_poll_timer #(
        .LIMIT (POLL_LIMIT)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (poll_clear),
        .step  (poll_step),
        .last  (poll_last)
    );

    dac_shadow_bank #(
        .N_CHAN (N_CHAN),
        .DATA_W (DATA_W)
    ) shadow_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_chan (commit_chan),
        .wr_data (commit_value),
        .rd_chan (rd_chan),
        .rd_data (rd_value)
    );
endmodule

// File: rtl/dac_upd_seq_chk.sv
module dac_upd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [3:0]  req_chan,
    input logic        req_ready,
    input logic        done_valid,
    input logic        done_err,
    input logic [2:0]  rd_chan,
    input logic [15:0] rd_value,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [2:0]  bus_addr,
    input logic [7:0]  bus_wdata
);
    // R5: a status read never shares a cycle with a write
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    // R5: reads only target the status offset
    a_r5_poll_addr: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_addr[1:0] == 2'd3));

    // R4, R7: command bytes carry setup or trigger opcode with bit 0 clear
    a_r4_cmd_form: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[1:0] == 2'd2) |->
            ((bus_wdata[7:4] == 4'h6 || bus_wdata[7:4] == 4'h7) && !bus_wdata[0]));

    // R10: out-of-range channel request leaves the block idle
    a_r10_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && req_chan >= 4'd8) |=> (req_ready && !bus_wr && !bus_rd));

    // R11: done lasts one cycle and the block is idle afterwards
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && req_ready));

    // R1: an idle sequencer drives no bus strobe
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_wr && !bus_rd));

    // R8: a shadow changes only together with a successful done
    a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rd_chan) && !$stable(rd_value)) |-> (done_valid && !done_err));
endmodule

bind dac_upd_seq dac_upd_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_chan   (req_chan),
    .req_ready  (req_ready),
    .done_valid (done_valid),
    .done_err   (done_err),
    .rd_chan    (rd_chan),
    .rd_value   (rd_value),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata)
);

// File: tb/dac_upd_seq_tb_top.sv
module dac_upd_seq_tb_top;
    localparam int L = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_chan = '0;
    logic [15:0] req_value = '0;
    logic [7:0]  req_range = '0;
    logic        req_ready, done_valid, done_err;
    logic [2:0]  rd_chan = '0;
    logic [15:0] rd_value;
    logic        bus_wr, bus_rd;
    logic [2:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;

    always #10 clk = ~clk;

    dac_upd_seq #(.POLL_LIMIT(L)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .req_value(req_value), .req_range(req_range), .req_ready(req_ready),
        .done_valid(done_valid), .done_err(done_err), .rd_chan(rd_chan),
        .rd_value(rd_value), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // device model and bus log
    int          delay1 = 0, delay2 = 0;
    int          poll_cnt = 0, phase = 0;
    logic        log_clr = 1'b0;
    int          wr_n = 0, poll_n = 0, done_n = 0, rd_bad = 0;
    logic [2:0]  la [16];
    logic [7:0]  ld [16];
    logic [2:0]  exp_rd_addr = '0;

    assign bus_rdata = (poll_cnt >= ((phase == 0) ? delay1 : delay2)) ? 8'h80 : 8'h7F;

    always @(posedge clk) begin
        if (log_clr) begin
            wr_n <= 0; poll_n <= 0; done_n <= 0; rd_bad <= 0;
        end else begin
            if (bus_wr) begin
                if (wr_n < 16) begin
                    la[wr_n] <= bus_addr;
                    ld[wr_n] <= bus_wdata;
                end
                wr_n <= wr_n + 1;
                if (bus_addr[1:0] == 2'd2) begin
                    poll_cnt <= 0;
                    phase    <= (bus_wdata[7:4] == 4'h7) ? 1 : 0;
                end
            end
            if (bus_rd) begin
                poll_cnt <= poll_cnt + 1;
                poll_n   <= poll_n + 1;
                if (bus_addr != exp_rd_addr) rd_bad <= rd_bad + 1;
            end
            if (done_valid) done_n <= done_n + 1;
        end
    end

    int checks = 0, failures = 0;
    logic [15:0] model [8];
    logic        last_err;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_shadows(input string tag);
        for (int c = 0; c < 8; c++) begin
            rd_chan = 3'(c);
            #1;
            chk(rd_value == model[c], tag, int'(rd_value), int'(model[c]));
        end
    endtask

    // run one update; expected traffic computed from the requirements
    task automatic run_upd(input int ch, input logic [15:0] val, input logic [7:0] rng,
                           input int d1, input int d2);
        int b, i, base, exp_wr, exp_polls, t;
        bit exp_err;
        b = ch / 4; i = ch % 4; base = 4 * b;
        exp_rd_addr = 3'(base + 3);
        @(negedge clk);
        delay1 = d1; delay2 = d2;
        req_valid = 1'b1; req_chan = 4'(ch); req_value = val; req_range = rng;
        log_clr = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; log_clr = 1'b0;
        t = 0;
        while (!done_valid && t < 500) begin @(negedge clk); t++; end
        last_err = done_err;
        chk(done_valid == 1'b1, "R11 done pulse seen", int'(done_valid), 1);
        if (d1 >= L) begin
            exp_wr = 3; exp_polls = L; exp_err = 1'b1;
        end else if (d2 >= L) begin
            exp_wr = 6; exp_polls = d1 + 1 + L; exp_err = 1'b1;
        end else begin
            exp_wr = 6; exp_polls = d1 + d2 + 2; exp_err = 1'b0;
        end
        chk(last_err == exp_err, exp_err ? "R9 error flag" : "R11 no error", int'(last_err), int'(exp_err));
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 ready after done", int'(req_ready), 1);
        chk(wr_n == exp_wr, exp_err ? "R9 write count" : "R2 write count", wr_n, exp_wr);
        chk(poll_n == exp_polls, exp_err ? "R9 poll count" : "R5 poll count", poll_n, exp_polls);
        chk(rd_bad == 0, "R5 poll address", rd_bad, 0);
        chk(done_n == 1, "R11 single done", done_n, 1);
        if (wr_n >= 3) begin
            chk(la[0] == 3'(base) && ld[0] == {4'h0, rng[3:0]}, "R3 range write",
                int'({la[0], ld[0]}), int'({3'(base), 4'h0, rng[3:0]}));
            chk(la[1] == 3'(base + 1) && ld[1] == 8'h00, "R3 zero write",
                int'({la[1], ld[1]}), int'({3'(base + 1), 8'h00}));
            chk(la[2] == 3'(base + 2) && ld[2] == (8'h60 | 8'(i << 1)), "R4 setup command",
                int'({la[2], ld[2]}), int'({3'(base + 2), 8'h60 | 8'(i << 1)}));
        end
        if (wr_n >= 6) begin
            chk(la[3] == 3'(base) && ld[3] == val[7:0], "R6 low byte",
                int'({la[3], ld[3]}), int'({3'(base), val[7:0]}));
            chk(la[4] == 3'(base + 1) && ld[4] == val[15:8], "R6 high byte",
                int'({la[4], ld[4]}), int'({3'(base + 1), val[15:8]}));
            chk(la[5] == 3'(base + 2) && ld[5] == (8'h70 | 8'(i << 1)), "R7 trigger command",
                int'({la[5], ld[5]}), int'({3'(base + 2), 8'h70 | 8'(i << 1)}));
        end
        if (!exp_err) model[ch] = val;
        check_shadows(exp_err ? "R9 shadow unchanged" : "R8 shadow readback");
    endtask

    task automatic run_ignored(input int ch);
        @(negedge clk);
        req_valid = 1'b1; req_chan = 4'(ch); req_value = 16'hDEAD; req_range = 8'h0F;
        log_clr = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; log_clr = 1'b0;
        repeat (20) @(negedge clk);
        chk(wr_n == 0 && poll_n == 0, "R10 no bus access", wr_n + poll_n, 0);
        chk(done_n == 0, "R10 no done", done_n, 0);
        chk(req_ready == 1'b1, "R10 stays ready", int'(req_ready), 1);
        check_shadows("R10 shadows untouched");
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < 8; c++) model[c] = 16'h0000;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
        chk(!bus_wr && !bus_rd && !done_valid, "R1 reset quiet",
            int'({bus_wr, bus_rd, done_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_shadows("R1 reset shadows");
        chk(req_ready == 1'b1, "R1 idle after reset", int'(req_ready), 1);

        // sweep all channels with a few ready delay pairs
        for (int ch = 0; ch < 8; ch++) begin
            for (int k = 0; k < 3; k++) begin
                run_upd(ch, 16'((ch + 1) * 16'h1357 + k * 16'h0F0F),
                        8'(8'hA0 + ch * 8'h11 + k), k * 2, 3 - k);
            end
        end

        // boundary: ready on the last allowed poll in both waits
        run_upd(3, 16'hBEEF, 8'h5C, L - 1, L - 1);
        run_upd(6, 16'h00FF, 8'hF3, L - 1, 0);
        // timeout in first wait
        run_upd(5, 16'h1234, 8'h07, L, 0);
        // timeout in second wait
        run_upd(2, 16'hCAFE, 8'h09, 1, L);
        run_upd(7, 16'h8001, 8'h11, 0, L + 3);
        // out-of-range channels ignored
        for (int ch = 8; ch < 16; ch += 3) run_ignored(ch);
        run_ignored(15);
        // still operates after an ignored request
        run_upd(4, 16'h7E57, 8'h02, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule